// File: doc/BRIEF.md
# Flash Bank Write Guard

This block decides, one request at a time, whether a program or erase operation may touch a given region of an on-chip flash. The flash is split into 4 KB banks. For each of three requesters (the embedded controller, the host and the debugger) the block holds a separate vector of write-protect bits, one bit per bank. A request presents a flash byte address and a source code. One cycle later the block answers with allow or deny. A denied request also raises a sticky violation flag and records the address that caused it.

Software configures protection through a small byte-wide register bus. A write can only turn protect bits on. Once a bit is set it stays set until a reset. A separate lock register freezes all protect registers. Its single bit can only be written to one. A warm reset does not clear it; only the power-on reset does. The warm reset clears the protect bits and the violation record.

Top module: `bank_guard`

## Requirements
- R1: After either reset (`rst` or `por`) every protect bit reads 0, `chk_valid` and `chk_allow` are 0, and `viol_flag` is 0.
- R2: A write of byte D to a protect register at byte index i sets bank bit i*8+k for every k where D[k] is 1. Bits where D[k] is 0 keep their value, so a set bit cannot be cleared by writing.
- R3: The register address `reg_addr[4:3]` selects a group: 0 is the controller array, 1 is the host array, 2 is the debugger array, 3 is the lock register. `reg_addr[2:0]` is the byte index. `reg_rdata` is registered and shows the addressed byte one cycle after `reg_addr` is presented. The lock register reads as {7'b0, lock}.
- R4: Writing a byte with bit 0 set to the lock register sets the lock. Writing 0 has no effect. Only `por` clears the lock.
- R5: While the lock is set, writes to all three protect arrays are ignored.
- R6: A request with `req_valid` high produces `chk_valid` high one cycle later. `chk_allow` is 1 only if the source code is 3'h4 (controller), 3'h1 (host) or 3'h2 (debugger), and the bank `req_addr[19:12]` is below NUM_BANKS, and that bank's bit in that source's own array is clear.
- R7: A request to a bank index at or above NUM_BANKS is denied. A request with any other source code is also denied.
- R8: A denied request sets `viol_flag` and latches its address into `viol_addr`, but only if the flag was clear. Later denials leave both unchanged until a reset.
- R9: `rst` clears the protect bits and the violation record but leaves the lock as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous warm reset, active high |
| por | input | 1 | Synchronous power-on reset, active high; also clears the lock |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address: group in bits 4:3, byte index in bits 2:0 |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| req_valid | input | 1 | Program/erase request present |
| req_addr | input | 20 | Flash byte address of the request |
| req_src | input | 3 | Requester code: 4 controller, 1 host, 2 debugger |
| chk_valid | output | 1 | Verdict valid, one cycle after the request |
| chk_allow | output | 1 | Verdict: 1 allow, 0 deny |
| viol_flag | output | 1 | Sticky: a request has been denied |
| viol_addr | output | 20 | Address of the first denied request |

## Verification
The bench targets the places where a flawed guard would be subtly wrong. A write of zeros must not clear bits; an implementation using plain stores would do so. A bit set for one requester must not leak into another, which tests the source decode. The top bank must be allowed while the first bank index past the flash is denied, which catches a bad bank comparison. Unknown source codes must be denied rather than falling through to some array. The violation record must keep its first address rather than the latest one. A warm reset must leave the lock standing, so protect writes stay ignored until `por`, which catches a lock wired to the wrong reset. Random requests from a seeded generator are compared against a bench model of the three arrays.

// File: rtl/bg_pkg.sv
package bg_pkg;
  localparam logic [2:0] SRC_HOST = 3'h1;
  localparam logic [2:0] SRC_DBG  = 3'h2;
  localparam logic [2:0] SRC_CTL  = 3'h4;

  typedef enum logic [1:0] {
    GRP_CTL  = 2'd0,
    GRP_HOST = 2'd1,
    GRP_DBG  = 2'd2,
    GRP_LOCK = 2'd3
  } grp_e;
endpackage

// File: rtl/bg_prot_array.sv
module bg_prot_array #(
  parameter int NUM_BANKS = 64,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 frozen,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [7:0]           wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [NUM_BANKS-1:0] bits,
  output logic [7:0]           rd_byte
);
  localparam int NBYTES = NUM_BANKS / 8;

  // set-only storage: each byte ORs in the written ones
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (clr)
        bits[b*8 +: 8] <= '0;
      else if (wr_en && !frozen && wr_idx == IDX_W'(b))
        bits[b*8 +: 8] <= bits[b*8 +: 8] | wr_data;
    end
  end

  always_comb begin
    rd_byte = '0;
    for (int b = 0; b < NBYTES; b++)
      if (rd_idx == IDX_W'(b)) rd_byte = bits[b*8 +: 8];
  end

  // R2: once set, no bit ever drops outside reset
  p_sticky_bits_r2: assert property (@(posedge clk) disable iff (clr)
    1'b1 |=> ((bits & $past(bits)) == $past(bits)));

  // R5: frozen array does not change
  p_frozen_hold_r5: assert property (@(posedge clk) disable iff (clr)
    frozen |=> $stable(bits));
endmodule

// File: rtl/bg_lock.sv
module bg_lock (
  input  logic clk,
  input  logic por,
  input  logic set_req,
  output logic lock
);
  always_ff @(posedge clk) begin
    if (por)          lock <= 1'b0;
    else if (set_req) lock <= 1'b1;
  end

  // R4: only power-on reset releases the lock
  p_lock_hold_r4: assert property (@(posedge clk) disable iff (por)
    lock |=> lock);
endmodule

// File: rtl/bg_req_check.sv
module bg_req_check
  import bg_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int NUM_BANKS  = 64,
  parameter int BANK_SHIFT = 12
) (
  input  logic                 clk,
  input  logic                 clr,
  input  logic [NUM_BANKS-1:0] ctl_bits,
  input  logic [NUM_BANKS-1:0] host_bits,
  input  logic [NUM_BANKS-1:0] dbg_bits,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [2:0]           req_src,
  output logic                 chk_valid,
  output logic                 chk_allow,
  output logic                 viol_flag,
  output logic [ADDR_W-1:0]    viol_addr
);
  localparam int BK_W = ADDR_W - BANK_SHIFT;
  localparam int BI_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic [BK_W-1:0]      bank;
  logic                 in_range;
  logic                 src_ok;
  logic [NUM_BANKS-1:0] sel_bits;
  logic                 ok;

  assign bank     = req_addr[ADDR_W-1:BANK_SHIFT];
  assign in_range = ({1'b0, bank} < (BK_W+1)'(NUM_BANKS));

  always_comb begin
    src_ok   = 1'b1;
    sel_bits = '1;
    case (req_src)
      SRC_CTL:  sel_bits = ctl_bits;
      SRC_HOST: sel_bits = host_bits;
      SRC_DBG:  sel_bits = dbg_bits;
      default:  src_ok   = 1'b0;
    endcase
  end

  assign ok = src_ok && in_range && !sel_bits[bank[BI_W-1:0]];

  always_ff @(posedge clk) begin
    if (clr) begin
      chk_valid <= 1'b0;
      chk_allow <= 1'b0;
      viol_flag <= 1'b0;
      viol_addr <= '0;
    end else begin
      chk_valid <= req_valid;
      chk_allow <= req_valid && ok;
      if (req_valid && !ok && !viol_flag) begin
        viol_flag <= 1'b1;
        viol_addr <= req_addr;
      end
    end
  end

  // R6: an allow never appears without a verdict
  p_allow_valid_r6: assert property (@(posedge clk) disable iff (clr)
    chk_allow |-> chk_valid);

  // R7: out-of-range bank is always denied
  p_oob_deny_r7: assert property (@(posedge clk) disable iff (clr)
    (req_valid && !in_range) |=> (chk_valid && !chk_allow));

  // R8: violation record is frozen once taken
  p_viol_keep_r8: assert property (@(posedge clk) disable iff (clr)
    viol_flag |=> (viol_flag && $stable(viol_addr)));
endmodule

// File: rtl/bank_guard.sv
module bank_guard
  import bg_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int NUM_BANKS  = 64,
  parameter int BANK_SHIFT = 12,
  localparam int NBYTES    = NUM_BANKS / 8,
  localparam int IDX_W     = (NBYTES > 1) ? $clog2(NBYTES) : 1,
  localparam int RA_W      = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_src,
  output logic              chk_valid,
  output logic              chk_allow,
  output logic              viol_flag,
  output logic [ADDR_W-1:0] viol_addr
);
  logic                 clr;
  logic                 lock;
  grp_e                 grp;
  logic [IDX_W-1:0]     idx;
  logic [NUM_BANKS-1:0] pbits   [3];
  logic [7:0]           rd_byte [3];

  assign clr = rst | por;
  assign grp = grp_e'(reg_addr[RA_W-1:IDX_W]);
  assign idx = reg_addr[IDX_W-1:0];

  for (genvar g = 0; g < 3; g++) begin : g_arr
    bg_prot_array #(.NUM_BANKS(NUM_BANKS), .IDX_W(IDX_W)) u_arr (
      .clk     (clk),
      .clr     (clr),
      .frozen  (lock),
      .wr_en   (reg_we && grp == grp_e'(g)),
      .wr_idx  (idx),
      .wr_data (reg_wdata),
      .rd_idx  (idx),
      .bits    (pbits[g]),
      .rd_byte (rd_byte[g])
    );
  end

  bg_lock u_lock (
    .clk     (clk),
    .por     (por),
    .set_req (reg_we && grp == GRP_LOCK && reg_wdata[0]),
    .lock    (lock)
  );

  always_ff @(posedge clk) begin
    if (clr)                 reg_rdata <= '0;
    else if (grp == GRP_LOCK) reg_rdata <= {7'b0, lock};
    else                     reg_rdata <= rd_byte[grp];
  end

  bg_req_check #(
    .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_SHIFT(BANK_SHIFT)
  ) u_chk (
    .clk       (clk),
    .clr       (clr),
    .ctl_bits  (pbits[0]),
    .host_bits (pbits[1]),
    .dbg_bits  (pbits[2]),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_src   (req_src),
    .chk_valid (chk_valid),
    .chk_allow (chk_allow),
    .viol_flag (viol_flag),
    .viol_addr (viol_addr)
  );

  // R9: warm reset alone keeps the lock state
  p_warm_keeps_lock_r9: assert property (@(posedge clk) disable iff (por)
    (rst && lock) |=> lock);
endmodule

// File: tb/bank_guard_tb.sv
`timescale 1ns/1ps
module bank_guard_tb;
  logic        clk = 0;
  logic        rst = 1, por = 1;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [7:0]  reg_wdata = 0;
  logic [7:0]  reg_rdata;
  logic        req_valid = 0;
  logic [19:0] req_addr = 0;
  logic [2:0]  req_src = 0;
  logic        chk_valid, chk_allow, viol_flag;
  logic [19:0] viol_addr;

  int vectors = 0, errors = 0;
  logic [63:0] m_bits [3];
  logic        m_lock = 0, m_viol = 0;
  logic [19:0] m_vaddr = 0;

  always #2.5 clk = ~clk;

  bank_guard u_dut (.*);

  task automatic expect_eq(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int grp_of(logic [2:0] s);
    case (s)
      3'h4: return 0;
      3'h1: return 1;
      3'h2: return 2;
      default: return -1;
    endcase
  endfunction

  function automatic logic exp_ok(logic [19:0] a, logic [2:0] s);
    int g = grp_of(s);
    int bk = int'(a[19:12]);
    if (g < 0 || bk >= 64) return 1'b0;
    return !m_bits[g][bk];
  endfunction

  task automatic do_write(logic [4:0] ra, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = ra; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    if (ra[4:3] == 2'd3) begin
      if (d[0]) m_lock = 1;
    end else if (!m_lock)
      m_bits[ra[4:3]][ra[2:0]*8 +: 8] |= d;
  endtask

  task automatic do_read(logic [4:0] ra, string tag);
    logic [7:0] e;
    e = (ra[4:3] == 2'd3) ? {7'b0, m_lock} : m_bits[ra[4:3]][ra[2:0]*8 +: 8];
    @(negedge clk); reg_addr = ra;
    @(negedge clk);
    expect_eq(tag, reg_rdata, e);
  endtask

  task automatic do_req(logic [19:0] a, logic [2:0] s, string tag);
    logic ok;
    ok = exp_ok(a, s);
    @(negedge clk); req_valid = 1; req_addr = a; req_src = s;
    @(negedge clk); req_valid = 0;
    if (!ok && !m_viol) begin m_viol = 1; m_vaddr = a; end
    expect_eq({tag, " valid"}, chk_valid, 1);
    expect_eq({tag, " allow"}, chk_allow, ok);
    expect_eq("R8 viol_flag", viol_flag, m_viol);
    expect_eq("R8 viol_addr", viol_addr, m_vaddr);
  endtask

  task automatic do_reset(logic power);
    @(negedge clk); rst = !power; por = power;
    @(negedge clk); rst = 0; por = 0;
    for (int g = 0; g < 3; g++) m_bits[g] = '0;
    m_viol = 0; m_vaddr = 0;
    if (power) m_lock = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int g = 0; g < 3; g++) m_bits[g] = '0;
    repeat (2) @(negedge clk);
    rst = 0; por = 0;
    @(negedge clk);
    // R1 reset state
    expect_eq("R1 chk_valid", chk_valid, 0);
    expect_eq("R1 chk_allow", chk_allow, 0);
    expect_eq("R1 viol_flag", viol_flag, 0);
    do_read(5'h00, "R1 ctl byte0");
    do_read(5'h18, "R4 lock after por");

    // R2 / R3 directed
    do_write(5'h00, 8'h05);
    do_read(5'h00, "R3 ctl byte0");
    do_write(5'h00, 8'h00);
    do_read(5'h00, "R2 zero write keeps bits");
    do_write(5'h00, 8'h02);
    do_read(5'h00, "R2 or-in bit1");
    do_read(5'h08, "R3 host byte0 untouched");
    // R6 per-source independence
    do_req(20'h00123, 3'h4, "R6 ctl bank0 deny");
    do_req(20'h03000, 3'h4, "R6 ctl bank3 allow");
    do_req(20'h00123, 3'h1, "R6 host bank0 allow");
    do_req(20'h02abc, 3'h2, "R6 dbg bank2 allow");
    // R7 out of range and bad source, R8 keeps first address
    do_req(20'h3f000, 3'h1, "R7 top bank allow");
    do_req(20'h40000, 3'h1, "R7 first oob deny");
    do_req(20'h05000, 3'h3, "R7 bad src deny");
    do_req(20'h05000, 3'h0, "R7 zero src deny");
    do_write(5'h0f, 8'h80);
    do_req(20'h3ffff, 3'h1, "R6 host top bank deny");
    do_req(20'h3ffff, 3'h2, "R6 dbg top bank allow");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int k = $urandom % 10;
      if (k < 2) begin
        logic [4:0] ra = {2'($urandom % 3), 3'($urandom)};
        do_write(ra, 8'($urandom & $urandom & $urandom));
      end else if (k < 4) begin
        do_read({2'($urandom % 3), 3'($urandom)}, "R3 random read");
      end else begin
        logic [19:0] a = ($urandom % 4 == 0) ? 20'($urandom) : {2'b00, 18'($urandom)};
        logic [2:0] s;
        int p = $urandom % 8;
        s = (p < 2) ? 3'h4 : (p < 4) ? 3'h1 : (p < 6) ? 3'h2 : 3'($urandom);
        do_req(a, s, "R6 random request");
      end
      if (it == 200) do_reset(1'b0);
    end

    // R4 / R5 lock
    do_write(5'h18, 8'hfe);
    do_read(5'h18, "R4 lock write0 ignored");
    do_write(5'h18, 8'h01);
    do_read(5'h18, "R4 lock set");
    do_read(5'h01, "R5 ctl byte1 before");
    do_write(5'h01, 8'hff);
    do_read(5'h01, "R5 ctl byte1 locked");
    do_write(5'h11, 8'hff);
    do_read(5'h11, "R5 dbg byte1 locked");

    // R9 warm reset keeps lock, clears bits
    do_reset(1'b0);
    do_read(5'h18, "R9 lock kept");
    do_read(5'h0f, "R9 host byte7 cleared");
    expect_eq("R9 viol cleared", viol_flag, 0);
    do_write(5'h02, 8'h10);
    do_read(5'h02, "R5 still locked after warm reset");
    do_req(20'h14000, 3'h4, "R9 ctl bank20 allow");

    // R4 power-on reset releases lock
    do_reset(1'b1);
    do_read(5'h18, "R4 lock cleared by por");
    expect_eq("R1 chk_valid after por", chk_valid, 0);
    do_write(5'h02, 8'h10);
    do_read(5'h02, "R2 write after por");
    do_req(20'h14000, 3'h4, "R6 ctl bank20 deny");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule